// File: doc/BRIEF.md
# Beam-Racing Tunnel Coordinate Pipeline

This block turns the raster position of the pixel being scanned into tunnel texture coordinates, one pixel per clock, with no per-pixel lookup storage. Each pixel's offset from a movable tunnel centre is pre-rotated into the right half-plane. Six unrolled vectoring CORDIC iterations, split over two registered stages of three, then give its polar angle and radius. A stage that interpolates between a small set of ring keypoints turns the radius into an inverse-distance depth. A final stage mixes angle, depth and a frame counter into a 6-bit grayscale texel.

The latency is fixed at five clocks. The video timing logic presents each pixel's coordinates five clocks before that pixel is displayed, together with an enable for pixels that carry data. Moving the centre inputs translates the whole tunnel, which shifts the apparent viewpoint. Pixels very close to the centre, where the inverse distance would blow up, are forced dark.

Top module: `tunnel_coord_gen`

## Requirements
- R1: A pixel is accepted on every clock. Its results appear on all outputs exactly 5 rising edges after it is presented, and consecutive pixels give consecutive results.
- R2: While the synchronous active-high reset is applied, every output register clears to zero on the next clock, even in the middle of a stream.
- R3: angle_o equals atan2(dy, dx) scaled to 256 counts per turn and taken modulo 256, within ±2 counts, over all four quadrants. Here dx = x_i − cx_i and dy = y_i − cy_i, so 64 counts means +dy and 128 counts means −dx.
- R4: radius_o equals G·sqrt(dx² + dy²) within ±3, where G ≈ 1.6465 is the six-iteration CORDIC gain, which the block does not remove.
- R5: For a lit pixel, depth_o approximates 65535 / radius_o within 2.5 % + 2 counts. It is linear between keys at radii (4+m)·2^(k+2), for m = 0..3 and k = 0..7, whose depth is floor(65535 / radius). This keeps depth_o between 15 and 4095.
- R6: A pixel with radius_o < 16 is never lit, even when enabled. Its depth_o and texel_o are 0.
- R7: A pixel presented with en_i = 0 produces lit_o = 0, depth_o = 0 and texel_o = 0.
- R8: For a lit pixel, texel_o = ((u XOR v) >> 2) mod 64. Here u = (angle_o + f) mod 256, v = (depth_o[11:4] + f) mod 256, and f is the frame_i value presented with that pixel.
- R9: The outputs depend on the pixel and centre only through dx and dy. Two pixels with the same offset from their centres give identical outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Pixel carries data |
| x_i | input | 10 | Pixel column |
| y_i | input | 10 | Pixel row |
| cx_i | input | 10 | Tunnel centre column |
| cy_i | input | 10 | Tunnel centre row |
| frame_i | input | 8 | Frame count, scrolls the texture |
| angle_o | output | 8 | Polar angle, 256 counts per turn |
| radius_o | output | 12 | Gain-scaled radius, saturating |
| depth_o | output | 12 | Interpolated inverse radius |
| lit_o | output | 1 | Pixel enabled and outside the dark disc |
| texel_o | output | 6 | Grayscale texel |

## Verification
Vectors on the axes, in every quadrant and just below the positive dx axis check that the quadrant pre-rotation is right. A wrong half-turn offset would put angles 128 counts off, and a broken wrap near 256 would show a near-full-turn error. Offsets of a few pixels and the exact centre test the dark disc: a wrong threshold would light a pixel whose depth would overflow. A single pixel sent into an idle pipeline shows an off-by-one latency. Equal offsets under two different centres show whether the centre is subtracted consistently. Large diagonal offsets test the radius width and the last ring keys.

// File: rtl/tunnel_pkg.sv
package tunnel_pkg;
  localparam int CW      = 10;            // pixel coordinate width
  localparam int FRAC    = 2;             // fraction bits kept in CORDIC
  localparam int VW      = CW + FRAC + 4; // signed vector width
  localparam int AW      = 12;            // internal angle width
  localparam int OAW     = 8;             // output angle width
  localparam int RW      = 12;            // radius width
  localparam int DW      = 12;            // depth width
  localparam int FW      = 8;             // frame width
  localparam int TW      = 6;             // texel width
  localparam int CSTAGES = 2;             // CORDIC pipeline stages
  localparam int ISTEPS  = 3;             // iterations per stage
  localparam int LAT     = CSTAGES + 3;   // prep + cordic + depth + out
  localparam int RSH     = 4;             // log2 of dark disc radius
  localparam int RMIN    = 1 << RSH;
  localparam int SUBB    = 2;             // sub-ring bits per octave
  localparam int OCTB    = $clog2(RW - RSH);
  localparam int NKEY    = ((RW - RSH) << SUBB) + 1;
  localparam int KB      = $clog2(NKEY);
  localparam int DEPTH_K = 65535;

  typedef struct packed {
    logic signed [VW-1:0] x;
    logic signed [VW-1:0] y;
    logic [AW-1:0]        ang;
    logic [FW-1:0]        frame;
    logic                 en;
  } vec_t;

  // atan(2^-n) in units of 4096 per turn
  function automatic logic [AW-1:0] atan_step(input int n);
    case (n)
      0: return AW'(512);
      1: return AW'(302);
      2: return AW'(160);
      3: return AW'(81);
      4: return AW'(41);
      5: return AW'(20);
      6: return AW'(10);
      7: return AW'(5);
      default: return '0;
    endcase
  endfunction

  // inverse-distance value at ring key j
  function automatic logic [DW-1:0] inv_key(input int j);
    int r;
    r = ((1 << SUBB) + (j % (1 << SUBB))) << ((j >> SUBB) + RSH - SUBB);
    return DW'(DEPTH_K / r);
  endfunction
endpackage

// File: rtl/tunnel_prep.sv
module tunnel_prep
  import tunnel_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          en_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] cx_i,
  input  logic [CW-1:0] cy_i,
  input  logic [FW-1:0] frame_i,
  output vec_t          out_q
);
  logic signed [CW+1:0] dx, dy;
  logic signed [VW-1:0] sx, sy;

  always_comb begin
    dx = $signed({2'b00, x_i}) - $signed({2'b00, cx_i});
    dy = $signed({2'b00, y_i}) - $signed({2'b00, cy_i});
    sx = $signed({{(VW-CW-2){dx[CW+1]}}, dx}) <<< FRAC;
    sy = $signed({{(VW-CW-2){dy[CW+1]}}, dy}) <<< FRAC;
  end

  // fold the left half-plane onto the right one, carrying a half turn
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      out_q <= '0;
    end else begin
      out_q.en    <= en_i;
      out_q.frame <= frame_i;
      if (dx < 0) begin
        out_q.x   <= -sx;
        out_q.y   <= -sy;
        out_q.ang <= AW'(1 << (AW-1));
      end else begin
        out_q.x   <= sx;
        out_q.y   <= sy;
        out_q.ang <= '0;
      end
    end
  end
endmodule

// File: rtl/tunnel_cordic_stage.sv
module tunnel_cordic_stage
  import tunnel_pkg::*;
#(
  parameter int STAGE = 0
) (
  input  logic clk_i,
  input  logic rst_i,
  input  vec_t in_i,
  output vec_t out_q
);
  vec_t nxt;
  logic signed [VW-1:0] tx, ty;

  always_comb begin
    nxt = in_i;
    tx  = '0;
    ty  = '0;
    for (int i = 0; i < ISTEPS; i++) begin
      tx = nxt.x;
      ty = nxt.y;
      if (ty >= 0) begin
        nxt.x   = tx + (ty >>> (STAGE*ISTEPS + i));
        nxt.y   = ty - (tx >>> (STAGE*ISTEPS + i));
        nxt.ang = nxt.ang + atan_step(STAGE*ISTEPS + i);
      end else begin
        nxt.x   = tx - (ty >>> (STAGE*ISTEPS + i));
        nxt.y   = ty + (tx >>> (STAGE*ISTEPS + i));
        nxt.ang = nxt.ang - atan_step(STAGE*ISTEPS + i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) out_q <= '0;
    else       out_q <= nxt;
  end

  // vectoring from the right half-plane only ever grows x
  assert_xpos_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !out_q.x[VW-1]);
endmodule

// File: rtl/tunnel_depth.sv
module tunnel_depth
  import tunnel_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_i,
  input  vec_t           in_i,
  output logic [OAW-1:0] angle_q,
  output logic [RW-1:0]  radius_q,
  output logic [DW-1:0]  depth_q,
  output logic           lit_q,
  output logic [FW-1:0]  frame_q
);
  localparam int FRB = RW - 1 - SUBB;

  logic [DW-1:0]      inv_tab [NKEY];
  logic [VW-1:0]      xr;
  logic [RW-1:0]      r;
  logic [3:0]         msb;
  logic [OCTB-1:0]    oct;
  logic [RW-2:0]      rn;
  logic [SUBB-1:0]    sub;
  logic [FRB-1:0]     fr;
  logic [KB-1:0]      idx;
  logic [DW-1:0]      key_lo, key_hi, diff, depth_n;
  logic [DW+FRB-1:0]  prod;
  logic [OAW-1:0]     angle_n;
  logic               lit_n;

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    assign inv_tab[g] = inv_key(g);
  end

  always_comb begin
    xr  = in_i.x >>> FRAC;
    r   = (|xr[VW-1:RW]) ? '1 : xr[RW-1:0];
    msb = '0;
    for (int b = 0; b < RW; b++) if (r[b]) msb = 4'(b);
    oct = (msb < RSH) ? '0 : OCTB'(msb - RSH);
    rn  = (RW-1)'(r << (RW - 1 - msb));
    sub = rn[RW-2 -: SUBB];
    fr  = rn[FRB-1:0];
    idx = KB'({oct, sub});
    key_lo  = inv_tab[idx];
    key_hi  = inv_tab[idx + 1'b1];
    diff    = key_lo - key_hi;
    prod    = diff * fr;
    depth_n = key_lo - DW'(prod >> FRB);
    lit_n   = in_i.en && (r >= RW'(RMIN));
    angle_n = OAW'((in_i.ang + AW'(1 << (AW-OAW-1))) >> (AW-OAW));
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      angle_q <= '0; radius_q <= '0; depth_q <= '0; lit_q <= 1'b0; frame_q <= '0;
    end else begin
      angle_q  <= angle_n;
      radius_q <= r;
      depth_q  <= lit_n ? depth_n : '0;
      lit_q    <= lit_n;
      frame_q  <= in_i.frame;
    end
  end

  assert_depth_band_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    lit_q |-> (depth_q >= DW'(DEPTH_K >> RW)) && (depth_q <= inv_key(0)));
endmodule

// File: rtl/tunnel_coord_gen.sv
module tunnel_coord_gen
  import tunnel_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic           en_i,
  input  logic [CW-1:0]  x_i,
  input  logic [CW-1:0]  y_i,
  input  logic [CW-1:0]  cx_i,
  input  logic [CW-1:0]  cy_i,
  input  logic [FW-1:0]  frame_i,
  output logic [OAW-1:0] angle_o,
  output logic [RW-1:0]  radius_o,
  output logic [DW-1:0]  depth_o,
  output logic           lit_o,
  output logic [TW-1:0]  texel_o
);
  vec_t           stage_v [CSTAGES+1];
  logic [OAW-1:0] angle_q;
  logic [RW-1:0]  radius_q;
  logic [DW-1:0]  depth_q;
  logic           lit_q;
  logic [FW-1:0]  frame_q;
  logic [OAW-1:0] u, v;

  tunnel_prep u_prep (
    .clk_i, .rst_i, .en_i, .x_i, .y_i, .cx_i, .cy_i, .frame_i,
    .out_q(stage_v[0])
  );

  for (genvar s = 0; s < CSTAGES; s++) begin : g_cordic
    tunnel_cordic_stage #(.STAGE(s)) u_stage (
      .clk_i, .rst_i, .in_i(stage_v[s]), .out_q(stage_v[s+1])
    );
  end

  tunnel_depth u_depth (
    .clk_i, .rst_i, .in_i(stage_v[CSTAGES]),
    .angle_q, .radius_q, .depth_q, .lit_q, .frame_q
  );

  always_comb begin
    u = angle_q + frame_q;
    v = depth_q[DW-1 -: OAW] + frame_q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      angle_o <= '0; radius_o <= '0; depth_o <= '0; lit_o <= 1'b0; texel_o <= '0;
    end else begin
      angle_o  <= angle_q;
      radius_o <= radius_q;
      depth_o  <= depth_q;
      lit_o    <= lit_q;
      texel_o  <= lit_q ? TW'((u ^ v) >> (OAW - TW)) : '0;
    end
  end

  assert_latency_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    lit_o |-> $past(en_i, LAT));
  assert_dark_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !lit_o |-> (texel_o == '0) && (depth_o == '0));
  assert_radius_floor_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    lit_o |-> (radius_o >= RW'(RMIN)));
endmodule

// File: tb/tunnel_coord_gen_bench.sv
module tunnel_coord_gen_bench;
  localparam int LAT = 5;
  localparam int NV  = 17;
  localparam real PI = 3.14159265358979;

  // {x, y, cx, cy, frame, en}
  localparam logic [48:0] VEC [NV] = '{
    {10'd420, 10'd240, 10'd320,  10'd240, 8'd0,   1'b1},
    {10'd320, 10'd340, 10'd320,  10'd240, 8'd3,   1'b1},
    {10'd220, 10'd240, 10'd320,  10'd240, 8'd9,   1'b1},
    {10'd320, 10'd140, 10'd320,  10'd240, 8'd17,  1'b1},
    {10'd400, 10'd300, 10'd320,  10'd240, 8'd40,  1'b1},
    {10'd250, 10'd180, 10'd320,  10'd240, 8'd77,  1'b1},
    {10'd400, 10'd239, 10'd320,  10'd240, 8'd100, 1'b1},
    {10'd322, 10'd241, 10'd320,  10'd240, 8'd5,   1'b1},
    {10'd320, 10'd240, 10'd320,  10'd240, 8'd5,   1'b1},
    {10'd0,   10'd0,   10'd1023, 10'd1023, 8'd130, 1'b1},
    {10'd639, 10'd479, 10'd0,    10'd0,   8'd250, 1'b1},
    {10'd420, 10'd240, 10'd320,  10'd240, 8'd60,  1'b0},
    {10'd500, 10'd100, 10'd320,  10'd240, 8'd200, 1'b1},
    {10'd320, 10'd0,   10'd320,  10'd300, 8'd1,   1'b1},
    {10'd20,  10'd470, 10'd600,  10'd30,  8'd66,  1'b1},
    {10'd337, 10'd248, 10'd320,  10'd240, 8'd12,  1'b1},
    {10'd150, 10'd420, 10'd330,  10'd200, 8'd255, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [9:0] x = '0, y = '0, cx = '0, cy = '0;
  logic [7:0] frame = '0;
  logic [7:0]  angle_o;
  logic [11:0] radius_o, depth_o;
  logic        lit_o;
  logic [5:0]  texel_o;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  real kg;

  always #10 clk = ~clk;

  tunnel_coord_gen u_tunnel_coord_gen (
    .clk_i(clk), .rst_i(rst), .en_i(en), .x_i(x), .y_i(y), .cx_i(cx), .cy_i(cy),
    .frame_i(frame), .angle_o, .radius_o, .depth_o, .lit_o, .texel_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic drive(input logic [48:0] v);
    x = v[48:39]; y = v[38:29]; cx = v[28:19]; cy = v[18:9];
    frame = v[8:1]; en = v[0];
  endtask

  // compare current outputs against the model for vector v
  task automatic check_vec(input logic [48:0] v);
    real dx, dy, aref, da, rref, dref;
    int  u, w, tex;
    bit  lit_exp;
    dx = real'(int'(v[48:39])) - real'(int'(v[28:19]));
    dy = real'(int'(v[38:29])) - real'(int'(v[18:9]));
    rref = kg * $sqrt(dx*dx + dy*dy);
    chk((real'(radius_o) - rref <= 3.0) && (rref - real'(radius_o) <= 3.0),
        "R4", "radius", int'(radius_o), int'(rref));
    if (rref > 20.0) begin
      aref = $atan2(dy, dx) * 256.0 / (2.0 * PI);
      if (aref < 0.0) aref = aref + 256.0;
      da = real'(angle_o) - aref;
      while (da > 128.0) da = da - 256.0;
      while (da < -128.0) da = da + 256.0;
      chk((da <= 2.0) && (da >= -2.0), "R3", "angle", int'(angle_o), int'(aref));
    end
    lit_exp = v[0] && (rref > 20.0);
    chk(lit_o == lit_exp, v[0] ? "R6" : "R7", "lit", int'(lit_o), int'(lit_exp));
    if (lit_exp) begin
      dref = 65535.0 / real'(radius_o);
      chk((real'(depth_o) - dref <= 0.025*dref + 2.0) &&
          (dref - real'(depth_o) <= 0.025*dref + 2.0),
          "R5", "depth", int'(depth_o), int'(dref));
      u   = (int'(angle_o) + int'(v[8:1])) % 256;
      w   = (int'(depth_o[11:4]) + int'(v[8:1])) % 256;
      tex = ((u ^ w) >> 2) % 64;
      chk(int'(texel_o) == tex, "R8", "texel", int'(texel_o), tex);
    end else begin
      chk(depth_o == 12'd0 && texel_o == 6'd0, v[0] ? "R6" : "R7", "dark depth/texel",
          int'(depth_o) + int'(texel_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    kg = 1.0;
    for (int i = 0; i < 6; i++) kg = kg * $sqrt(1.0 + 2.0 ** (-2.0 * i));

    // reset state, R2
    repeat (4) @(negedge clk);
    chk(angle_o == 0 && radius_o == 0 && depth_o == 0 && !lit_o && texel_o == 0,
        "R2", "outputs in reset", int'(radius_o) + int'(depth_o), 0);
    rst = 1'b0;

    // streaming table, one pixel per clock (R1, R3..R8)
    for (int k = 0; k < NV + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) check_vec(VEC[k-LAT]);
      if (k < NV) drive(VEC[k]); else en = 1'b0;
    end

    // exact latency of a lone pixel, R1
    repeat (3) @(negedge clk);
    drive(VEC[0]);
    for (int c = 1; c <= LAT + 1; c++) begin
      @(negedge clk);
      en = 1'b0;
      chk(lit_o == (c == LAT), "R1", $sformatf("lit after %0d clocks", c),
          int'(lit_o), int'(c == LAT));
    end

    // translation invariance, R9
    begin
      int a1, r1, d1, t1;
      drive({10'd400, 10'd300, 10'd320, 10'd240, 8'd7, 1'b1});
      @(negedge clk); en = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      a1 = int'(angle_o); r1 = int'(radius_o); d1 = int'(depth_o); t1 = int'(texel_o);
      drive({10'd100, 10'd80, 10'd20, 10'd20, 8'd7, 1'b1});
      @(negedge clk); en = 1'b0;
      repeat (LAT - 1) @(negedge clk);
      chk(int'(angle_o) == a1 && int'(radius_o) == r1, "R9", "angle/radius moved centre",
          int'(angle_o) * 4096 + int'(radius_o), a1 * 4096 + r1);
      chk(int'(depth_o) == d1 && int'(texel_o) == t1, "R9", "depth/texel moved centre",
          int'(depth_o) * 64 + int'(texel_o), d1 * 64 + t1);
    end

    // reset in the middle of a stream, R2
    for (int k = 0; k < LAT + 1; k++) begin
      @(negedge clk);
      drive(VEC[k]);
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(angle_o == 0 && radius_o == 0 && depth_o == 0 && !lit_o && texel_o == 0,
        "R2", "outputs after mid-stream reset", int'(radius_o) + int'(lit_o), 0);
    en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    repeat (LAT + 1) @(negedge clk);
    chk(!lit_o && texel_o == 0, "R7", "idle after reset", int'(lit_o), 0);

    finish_run();
  end
endmodule